// File: doc/BRIEF.md
# Asynchronous 16-bit Register Bus Slave

This block lets a host processor reach a chip's registers and its data buffer over a plain 16-bit asynchronous memory bus. The bus has an active-low chip select, separate active-low read and write strobes, a nine-bit address and two active-low byte enables. The control strobes are brought into the core clock domain through a two-flop synchroniser, and their edges are detected there. The core side sees single-cycle pulses for register reads and writes and for buffer pushes and pops, together with an address and a byte-lane mask.

The ninth address line works as a window switch. While it is low, the low eight address lines pick one byte location in a 256-byte register space. While it is high, every access goes to one buffer data port, whatever the other address lines hold. Write data, address and byte enables are held in the core domain while the synchronised write strobe is low. The access completes on the synchronised rising edge of the write strobe. Read data is steered combinationally from the core onto the bus lanes that the byte enables select.

Top module: `asb_top`

## Requirements
- R1: After reset, every core-side strobe (register read, register write, buffer push, buffer pop) is low and the bus output enable is low.
- R2: A write with address bit 8 low and a byte enable code other than 11b produces exactly one register-write pulse per write-strobe rising edge. The pulse carries the address bits 7:0 and the 16-bit data that were on the bus while the strobe was low.
- R3: A write with address bit 8 high produces exactly one buffer-push pulse carrying the bus data, and no register-write pulse, whatever address bits 7:0 hold.
- R4: The write lane mask is bit 0 for D[7:0] and bit 1 for D[15:8]. Byte enable code 10b (bit 1 high, bit 0 low) gives mask 01b, code 01b gives mask 10b, and code 00b gives mask 11b.
- R5: Byte enable code 11b makes any access a no-op: no strobe of any kind, and a read drives zero on the bus.
- R6: During a read, a bus lane whose byte enable is low carries the matching byte of the selected word, and a lane whose byte enable is high reads as zero.
- R7: A read with address bit 8 low gives exactly one register-read pulse per access. Address bits 7:0 are presented on the register read address, and the register read data appears on the bus.
- R8: A read with address bit 8 high shows the buffer read word on the bus and gives exactly one buffer-pop pulse per read-strobe rising edge, whatever address bits 7:0 hold.
- R9: The bus output enable is high only while chip select and read strobe are both low.
- R10: A write strobe pulsed while chip select is high is ignored and produces no strobe.
- R11: Every core-side strobe is a single-cycle pulse, and no register-write pulse coincides with a buffer-push pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busCsN | input | 1 | Chip select, active low |
| busRdN | input | 1 | Read strobe, active low |
| busWrN | input | 1 | Write strobe, active low |
| busBeN | input | 2 | Byte enables, active low, bit 1 for D[15:8] |
| busAddr | input | 9 | Bus address; bit 8 selects the buffer window |
| busDataIn | input | 16 | Write data from the bus |
| busDataOut | output | 16 | Read data to the bus |
| busDataOe | output | 1 | Bus output enable |
| regWrStrb | output | 1 | Register write pulse |
| regWrAddr | output | 8 | Register write address |
| wrLaneMask | output | 2 | Byte lanes written |
| wrData | output | 16 | Write data for register or buffer |
| regRdStrb | output | 1 | Register read pulse |
| regRdAddr | output | 8 | Register read address |
| regRdData | input | 16 | Register read data from the core |
| bufPush | output | 1 | Buffer push pulse |
| bufPop | output | 1 | Buffer pop pulse |
| bufRdData | input | 16 | Current buffer read word |

## Verification
A buffer read and a following buffer write are run back to back with no idle gap. This sets the pop from the end of the read right next to the capture window of the write. Each is judged by counting exactly one pop and exactly one push with the right data. The sweep crosses both window settings, all four byte enable codes and low address patterns that should be ignored in the buffer window. Each access is checked for how many pulses of each kind it produced, not only for whether a pulse appeared.

// File: rtl/asb_pkg.sv
package asb_pkg;
  typedef struct packed {
    logic capWr;
    logic regWr;
    logic bufPush;
    logic regRd;
    logic bufPop;
  } asbStrobes_t;

  function automatic logic [1:0] beToMask(input logic [1:0] beN);
    return ~beN;
  endfunction
endpackage

// File: rtl/asb_sync.sv
module asb_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/asb_ctrl.sv
module asb_ctrl
  import asb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csS,
  input  logic        rdS,
  input  logic        wrS,
  input  logic        busWinHi,
  input  logic [1:0]  busBeN,
  input  logic        heldWinHi,
  input  logic [1:0]  heldBeN,
  output asbStrobes_t strobes
);
  logic wrPrev, rdPrev, wrPend, rdPend, rdBuf, rdNop;
  logic regWrQ, bufPushQ, regRdQ, bufPopQ;
  logic wrRise, rdFall, rdRise, capWr;

  assign wrRise = !wrPrev && wrS;
  assign rdFall = rdPrev && !rdS;
  assign rdRise = !rdPrev && rdS;
  assign capWr  = !wrS && !csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b1;
      rdPrev   <= 1'b1;
      wrPend   <= 1'b0;
      rdPend   <= 1'b0;
      rdBuf    <= 1'b0;
      rdNop    <= 1'b0;
      regWrQ   <= 1'b0;
      bufPushQ <= 1'b0;
      regRdQ   <= 1'b0;
      bufPopQ  <= 1'b0;
    end else begin
      wrPrev <= wrS;
      rdPrev <= rdS;
      if (capWr) wrPend <= 1'b1;
      else if (wrRise) wrPend <= 1'b0;
      regWrQ   <= wrRise && wrPend && !heldWinHi && (heldBeN != 2'b11);
      bufPushQ <= wrRise && wrPend && heldWinHi && (heldBeN != 2'b11);
      regRdQ   <= rdFall && !csS && !busWinHi && (busBeN != 2'b11);
      bufPopQ  <= rdRise && rdPend && rdBuf && !rdNop;
      if (rdFall && !csS) begin
        rdPend <= 1'b1;
        rdBuf  <= busWinHi;
        rdNop  <= (busBeN == 2'b11);
      end else if (rdRise) begin
        rdPend <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.capWr   = capWr;
    strobes.regWr   = regWrQ;
    strobes.bufPush = bufPushQ;
    strobes.regRd   = regRdQ;
    strobes.bufPop  = bufPopQ;
  end
endmodule

// File: rtl/asb_dp.sv
module asb_dp
  import asb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  asbStrobes_t       strobes,
  input  logic              busCsN,
  input  logic              busRdN,
  input  logic [LANES-1:0]  busBeN,
  input  logic [ADDR_W:0]   busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] bufRdData,
  output logic [ADDR_W:0]   heldAddr,
  output logic [LANES-1:0]  heldBeN,
  output logic [DATA_W-1:0] heldData,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe
);
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldBeN  <= '1;
      heldData <= '0;
    end else if (strobes.capWr) begin
      heldAddr <= busAddr;
      heldBeN  <= busBeN;
      heldData <= busDataIn;
    end
  end

  assign rdWord    = busAddr[ADDR_W] ? bufRdData : regRdData;
  assign busDataOe = !busCsN && !busRdN;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign busDataOut[g*8 +: 8] = busBeN[g] ? 8'h00 : rdWord[g*8 +: 8];
  end
endmodule

// File: rtl/asb_top.sv
module asb_top
  import asb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic [LANES-1:0]  busBeN,
  input  logic [ADDR_W:0]   busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              regWrStrb,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [LANES-1:0]  wrLaneMask,
  output logic [DATA_W-1:0] wrData,
  output logic              regRdStrb,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [DATA_W-1:0] regRdData,
  output logic              bufPush,
  output logic              bufPop,
  input  logic [DATA_W-1:0] bufRdData
);
  logic [2:0]        syncCtl;
  asbStrobes_t       strobes;
  logic [ADDR_W:0]   heldAddr;
  logic [LANES-1:0]  heldBeN;

  asb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({busCsN, busRdN, busWrN}),
    .syncOut(syncCtl)
  );

  asb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .csS(syncCtl[2]), .rdS(syncCtl[1]), .wrS(syncCtl[0]),
    .busWinHi(busAddr[ADDR_W]), .busBeN(busBeN),
    .heldWinHi(heldAddr[ADDR_W]), .heldBeN(heldBeN),
    .strobes(strobes)
  );

  asb_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busCsN(busCsN), .busRdN(busRdN), .busBeN(busBeN),
    .busAddr(busAddr), .busDataIn(busDataIn),
    .regRdData(regRdData), .bufRdData(bufRdData),
    .heldAddr(heldAddr), .heldBeN(heldBeN), .heldData(wrData),
    .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

  assign regWrStrb  = strobes.regWr;
  assign bufPush    = strobes.bufPush;
  assign regRdStrb  = strobes.regRd;
  assign bufPop     = strobes.bufPop;
  assign regWrAddr  = heldAddr[ADDR_W-1:0];
  assign wrLaneMask = beToMask(heldBeN);
  assign regRdAddr  = busAddr[ADDR_W-1:0];
endmodule

// File: rtl/asb_checker.sv
module asb_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busCsN,
  input logic              busRdN,
  input logic              busDataOe,
  input logic              regWrStrb,
  input logic              bufPush,
  input logic              regRdStrb,
  input logic              bufPop,
  input logic [1:0]        wrLaneMask,
  input logic [ADDR_W-1:0] regWrAddr
);
  // R11
  wr_mutex_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrStrb, bufPush}));
  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrb |=> !regWrStrb);
  // R8
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufPop |=> !bufPop);
  // R11
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufPush |=> !bufPush);
  // R5
  lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrStrb || bufPush) |-> (wrLaneMask != 2'b00));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrb |-> $stable(regWrAddr));
  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (!busCsN && !busRdN));
  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdStrb |=> !regRdStrb);
endmodule

bind asb_top asb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busCsN(busCsN), .busRdN(busRdN),
  .busDataOe(busDataOe), .regWrStrb(regWrStrb), .bufPush(bufPush),
  .regRdStrb(regRdStrb), .bufPop(bufPop), .wrLaneMask(wrLaneMask),
  .regWrAddr(regWrAddr)
);

// File: tb/asb_top_tb_top.sv
`timescale 1ns/1ps
module asb_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCsN = 1'b1, busRdN = 1'b1, busWrN = 1'b1;
  logic [1:0]  busBeN = 2'b11;
  logic [8:0]  busAddr = '0;
  logic [15:0] busDataIn = '0;
  logic [15:0] busDataOut, wrData, regRdData, bufRdData;
  logic        busDataOe, regWrStrb, regRdStrb, bufPush, bufPop;
  logic [7:0]  regWrAddr, regRdAddr;
  logic [1:0]  wrLaneMask;
  int          checks = 0, fails = 0, popCnt = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  asb_top dut_i (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busBeN(busBeN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe),
    .regWrStrb(regWrStrb), .regWrAddr(regWrAddr), .wrLaneMask(wrLaneMask),
    .wrData(wrData), .regRdStrb(regRdStrb), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .bufPush(bufPush), .bufPop(bufPop),
    .bufRdData(bufRdData)
  );

  assign regRdData = {~regRdAddr, regRdAddr};
  assign bufRdData = 16'hA500 + 16'(popCnt);

  always @(posedge clk) if (bufPop) popCnt <= popCnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] laneSel(input logic [15:0] w, input logic [1:0] beN);
    return {beN[1] ? 8'h00 : w[15:8], beN[0] ? 8'h00 : w[7:0]};
  endfunction

  task automatic doWrite(input logic cs, input logic [8:0] a, input logic [1:0] be,
                         input logic [15:0] d, output int nReg, output int nPush,
                         output logic [7:0] gotA, output logic [15:0] gotD,
                         output logic [1:0] gotM);
    nReg = 0; nPush = 0; gotA = '0; gotD = '0; gotM = '0;
    @(negedge clk);
    busCsN = !cs; busAddr = a; busBeN = be; busDataIn = d;
    @(negedge clk); busWrN = 1'b0;
    repeat (4) @(negedge clk);
    busWrN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (regWrStrb) begin nReg++; gotA = regWrAddr; gotD = wrData; gotM = wrLaneMask; end
      if (bufPush) begin nPush++; gotD = wrData; gotM = wrLaneMask; end
    end
    busCsN = 1'b1;
  endtask

  task automatic doRead(input logic [8:0] a, input logic [1:0] be, output int nRd,
                        output int nPop, output logic [15:0] got, output logic oe,
                        output logic [15:0] expW);
    nRd = 0; nPop = 0;
    @(negedge clk);
    busCsN = 1'b0; busAddr = a; busBeN = be;
    @(negedge clk); busRdN = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (regRdStrb) nRd++;
    end
    got = busDataOut; oe = busDataOe;
    expW = a[8] ? (16'hA500 + 16'(popCnt)) : {~a[7:0], a[7:0]};
    busRdN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bufPop) nPop++;
      if (regRdStrb) nRd++;
    end
    busCsN = 1'b1;
  endtask

  initial begin
    int nReg, nPush, nRd, nPop;
    logic [7:0] gA;
    logic [15:0] gD, got, expW;
    logic [1:0] gM, expM;
    logic oe;
    logic [7:0] pats [3] = '{8'h00, 8'h5A, 8'hFF};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({regWrStrb, regRdStrb, bufPush, bufPop, busDataOe} == 5'b0, "R1",
        {regWrStrb, regRdStrb, bufPush, bufPop, busDataOe}, 0);

    for (int hi = 0; hi < 2; hi++)
      for (int be = 0; be < 4; be++)
        for (int p = 0; p < 3; p++) begin
          logic [8:0] a;
          logic [15:0] d;
          logic live;
          a = {hi[0], pats[p]};
          d = {pats[p] ^ 8'h3C, 4'(be), 4'(hi) + 4'h7};
          live = (be != 3);
          expM = ~be[1:0];
          doWrite(1'b1, a, be[1:0], d, nReg, nPush, gA, gD, gM);
          if (!live) begin
            chk(nReg == 0 && nPush == 0, "R5 write no-op", nReg + nPush, 0);
          end else if (hi == 1) begin
            chk(nPush == 1 && nReg == 0, "R3 push count", {nPush[15:0], nReg[15:0]}, 32'h10000);
            chk(gD == d, "R3 push data", gD, d);
            chk(gM == expM, "R4 lane mask", gM, expM);
          end else begin
            chk(nReg == 1 && nPush == 0, "R2 write count", {nReg[15:0], nPush[15:0]}, 32'h10000);
            chk(gA == a[7:0] && gD == d, "R2 addr/data", {gA, gD}, {a[7:0], d});
            chk(gM == expM, "R4 lane mask", gM, expM);
          end
          doRead(a, be[1:0], nRd, nPop, got, oe, expW);
          chk(oe == 1'b1, "R9 oe during read", oe, 1);
          chk(got == laneSel(expW, be[1:0]), live ? "R6 read lanes" : "R5 read zero",
              got, laneSel(expW, be[1:0]));
          if (hi == 1)
            chk(nPop == (live ? 1 : 0) && nRd == 0, "R8 pop count", nPop, live ? 1 : 0);
          else
            chk(nRd == (live ? 1 : 0) && nPop == 0, "R7 read strobe count", nRd, live ? 1 : 0);
          @(negedge clk);
          chk(busDataOe == 1'b0, "R9 oe idle", busDataOe, 0);
        end

    // R10 write strobe without chip select
    doWrite(1'b0, 9'h012, 2'b00, 16'hBEEF, nReg, nPush, gA, gD, gM);
    chk(nReg == 0 && nPush == 0, "R10 no cs", nReg + nPush, 0);

    // R8 / R3 back-to-back buffer read then buffer write
    doRead(9'h1C3, 2'b00, nRd, nPop, got, oe, expW);
    chk(nPop == 1 && got == expW, "R8 b2b pop", {nPop[15:0], got}, {16'd1, expW});
    doWrite(1'b1, 9'h13C, 2'b00, 16'h1234, nReg, nPush, gA, gD, gM);
    chk(nPush == 1 && gD == 16'h1234, "R3 b2b push", {nPush[15:0], gD}, {16'd1, 16'h1234});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule